// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address of every beat in a four-beat synchronous memory burst. A start address is captured on a rising clock edge whenever either of two independent active-low load strobes is low. After that, the block forms each following beat address itself. It moves one beat forward on each clock edge at which the active-low advance input is low, and it holds its place when advance is high.

A static order-select input chooses how the two low address bits move through the burst. In linear order they count up from the loaded value and wrap modulo four. In interleaved order, beat n uses the loaded low bits XOR n. The upper address bits never change during a burst. A load strobe that arrives in the middle of a burst starts a new burst at beat 0.

The output is registered state, so a memory controller can use it directly as the array address. The first beat is valid one cycle after the load edge, and each later beat is valid one cycle after its advance edge. This fits a 3-1-1-1 access pattern.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low and after its release, beat_addr is all zeros and beat_num is 0 until the first load.
- R2: A clock edge with strobe_a_n low copies addr_in into the sequencer; after that edge beat_addr equals the captured address and beat_num is 0.
- R3: A clock edge with strobe_b_n low and strobe_a_n high loads addr_in in the same way as R2, with no dependence on the other strobe.
- R4: A clock edge with both strobes high and advance_n low raises beat_num by one, wrapping from 3 to 0.
- R5: A clock edge with both strobes high and advance_n high leaves beat_num and beat_addr unchanged.
- R6: With order_sel = 0 (linear), beat_addr[1:0] equals (loaded low bits + beat_num) modulo 4.
- R7: With order_sel = 1 (interleaved), beat_addr[1:0] equals loaded low bits XOR beat_num.
- R8: beat_addr[ADDR_W-1:2] keeps the loaded value on every edge without a load, whatever advance_n does.
- R9: A load on any edge, including the middle of a burst and with advance_n low, takes priority: it reloads the address and sets beat_num back to 0.
- R10: Four advances after a load bring beat_addr back to the loaded address in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | Start address, sampled when a strobe is low |
| strobe_a_n | input | 1 | First active-low load strobe |
| strobe_b_n | input | 1 | Second active-low load strobe |
| advance_n | input | 1 | Active-low step request |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_num | output | 2 | Index of the current beat within the burst |

## Verification
Every result is a registered value. A load or an advance presented before edge k therefore appears on beat_addr and beat_num right after edge k, and a held cycle shows the same value after that edge. The bench changes inputs 2 ns after a rising edge and samples 2 ns after the next rising edge, so each check reads exactly the state that one edge produced. The expected addresses come from a small reference function in the bench that implements the linear-sum and XOR rules. Each check reads its value from that function at the beat index the bench has counted.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst beat address sequencer.
// Assumes: one-bit order select, where 0 selects linear and 1 selects interleaved.
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_load_ctrl.sv
// Module: burst_load_ctrl
// Merges the two active-low load strobes into one load request.
// Holds the captured start address until the next load.
// Assumes: both strobes are synchronous to clk; reset is synchronous and active low.
module burst_load_ctrl #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              load,
    output logic [ADDR_W-1:0] base_q
);

    // Load request: either strobe low is enough.
    always_comb begin
        load = (~strobe_a_n) | (~strobe_b_n);
    end

    // Capture the start address on a load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
        end
    end

endmodule

// File: rtl/burst_beat_counter.sv
// Module: burst_beat_counter
// Beat index counter. A load clears it; an advance with no load increments it,
// wrapping modulo 2**BEAT_W. Otherwise it holds.
// Assumes: load has priority over advance_n.
module burst_beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance_n,
    output logic [BEAT_W-1:0] count_q
);

    // Beat index update: clear on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= '0;
        end else if (!advance_n) begin
            count_q <= count_q + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Purely combinational. Forms the low beat-address bits from the loaded low
// bits and the beat index, using either a wrapping sum or a bitwise XOR.
// Assumes: order_sel is static for the length of a burst.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              order_sel,
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] count,
    output logic [BEAT_W-1:0] lo_out
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear order: sum that wraps inside the burst window.
    always_comb begin
        lin_lo = base_lo + count;
    end

    // Interleaved order: one XOR per address bit.
    for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_ilv_bit
        assign ilv_lo[gi] = base_lo[gi] ^ count[gi];
    end

    // Pick the order requested by order_sel.
    always_comb begin
        if (burst_order_e'(order_sel) == ORD_INTERLEAVE) begin
            lo_out = ilv_lo;
        end else begin
            lo_out = lin_lo;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst beat address sequencer. Loads a start address on either strobe and
// steps the low BEAT_W bits through a linear or interleaved sequence on each
// advance. The upper bits are held from the load.
// Assumes: synchronous active-low reset; order_sel is static during a burst.
module burst_addr_seq #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_a_n,
    input  logic              strobe_b_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [BEAT_W-1:0] beat_num
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] count_q;
    logic [BEAT_W-1:0] lo_bits;

    burst_load_ctrl #(.ADDR_W(ADDR_W)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .addr_in    (addr_in),
        .load       (load),
        .base_q     (base_q)
    );

    burst_beat_counter #(.BEAT_W(BEAT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance_n (advance_n),
        .count_q   (count_q)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_sel (order_sel),
        .base_lo   (base_q[BEAT_W-1:0]),
        .count     (count_q),
        .lo_out    (lo_bits)
    );

    // Join the held upper bits with the mapped low bits.
    always_comb begin
        beat_addr = {base_q[ADDR_W-1 -: HI_W], lo_bits};
        beat_num  = count_q;
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Protocol checker for burst_addr_seq. It watches only the top-level ports and
// is attached to the top module with a bind statement.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_a_n,
    input logic              strobe_b_n,
    input logic              advance_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [BEAT_W-1:0] beat_num
);

    logic ld_seen;

    // Load condition as seen at the ports.
    always_comb begin
        ld_seen = !strobe_a_n || !strobe_b_n;
    end

    // R2 R3 R9
    load_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_seen |=> (beat_addr == $past(addr_in)) && (beat_num == '0));

    // R4
    advance_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && !advance_n) |=> beat_num == BEAT_W'($past(beat_num) + 1'b1));

    // R5
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && advance_n) |=> $stable(beat_num) && $stable(beat_addr));

    // R8
    upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_seen |=> $stable(beat_addr[ADDR_W-1:BEAT_W]));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && !advance_n && !order_sel) |=>
        (order_sel || beat_addr[BEAT_W-1:0] == BEAT_W'($past(beat_addr[BEAT_W-1:0]) + 1'b1)));

    // R7
    interleave_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && order_sel) |=>
        (!order_sel || (beat_addr[BEAT_W-1:0] ^ beat_num) ==
                       $past(beat_addr[BEAT_W-1:0] ^ beat_num)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strobe_a_n (strobe_a_n),
    .strobe_b_n (strobe_b_n),
    .advance_n  (advance_n),
    .order_sel  (order_sel),
    .beat_addr  (beat_addr),
    .beat_num   (beat_num)
);

// File: tb/test_burst_addr_seq.sv
// Directed bench for burst_addr_seq. Inputs change 2 ns after a rising edge;
// outputs are read 2 ns after the following rising edge.
module test_burst_addr_seq;

    localparam int ADDR_W = 20;
    localparam int BEAT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strobe_a_n = 1'b1;
    logic              strobe_b_n = 1'b1;
    logic              advance_n = 1'b1;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] beat_addr;
    logic [BEAT_W-1:0] beat_num;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .strobe_a_n (strobe_a_n),
        .strobe_b_n (strobe_b_n),
        .advance_n  (advance_n),
        .order_sel  (order_sel),
        .beat_addr  (beat_addr),
        .beat_num   (beat_num)
    );

    // Reference address from the requirements: R6 linear sum, R7 XOR.
    function automatic logic [ADDR_W-1:0] ref_addr(logic [ADDR_W-1:0] base,
                                                   logic [1:0] n, logic ilv);
        logic [1:0] lo;
        lo = ilv ? (base[1:0] ^ n) : (base[1:0] + n);
        return {base[ADDR_W-1:2], lo};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R2/R3: one load through the chosen strobe, then check beat 0.
    task automatic do_load(logic [ADDR_W-1:0] a, bit use_b, string req);
        addr_in = a;
        if (use_b) strobe_b_n = 1'b0; else strobe_a_n = 1'b0;
        advance_n = 1'b1;
        step();
        strobe_a_n = 1'b1;
        strobe_b_n = 1'b1;
        addr_in = ~a;
        chk(req, beat_addr, a);
        chk(req, ADDR_W'(beat_num), '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        chk("R1", beat_addr, '0);
        chk("R1", ADDR_W'(beat_num), '0);
        rst_n = 1'b1;
        step();
        chk("R1", beat_addr, '0);
        chk("R1", ADDR_W'(beat_num), '0);
    endtask

    // Full burst in either order, ending with R10 wrap to the loaded address.
    task automatic t_full_burst(logic [ADDR_W-1:0] a, bit use_b, bit ilv);
        string rq;
        order_sel = ilv;
        do_load(a, use_b, use_b ? "R3" : "R2");
        rq = ilv ? "R7" : "R6";
        for (int n = 1; n <= 4; n++) begin
            advance_n = 1'b0;
            step();
            chk("R4", ADDR_W'(beat_num), ADDR_W'(n % 4));
            chk(rq, beat_addr, ref_addr(a, 2'(n), ilv));
            chk("R8", ADDR_W'(beat_addr[ADDR_W-1:2]), ADDR_W'(a[ADDR_W-1:2]));
        end
        advance_n = 1'b1;
        chk("R10", beat_addr, a);
    endtask

    // R5: idle cycles between advances leave the beat in place.
    task automatic t_hold();
        logic [ADDR_W-1:0] a = 20'hABCD6;
        order_sel = 1'b1;
        do_load(a, 1'b0, "R2");
        advance_n = 1'b0;
        step();
        advance_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5", beat_addr, ref_addr(a, 2'd1, 1'b1));
            chk("R5", ADDR_W'(beat_num), 1);
        end
    endtask

    // R9: reload in mid-burst with advance_n still low.
    task automatic t_reload();
        logic [ADDR_W-1:0] a = 20'h12341;
        logic [ADDR_W-1:0] b = 20'hF00F3;
        order_sel = 1'b0;
        do_load(a, 1'b1, "R3");
        advance_n = 1'b0;
        step();
        step();
        chk("R4", beat_addr, ref_addr(a, 2'd2, 1'b0));
        addr_in = b;
        strobe_a_n = 1'b0;
        step();
        strobe_a_n = 1'b1;
        chk("R9", beat_addr, b);
        chk("R9", ADDR_W'(beat_num), 0);
        step();
        advance_n = 1'b1;
        chk("R9", beat_addr, ref_addr(b, 2'd1, 1'b0));
    endtask

    // R3: both strobes low together still give a single clean load.
    task automatic t_both_strobes();
        addr_in = 20'h55552;
        strobe_a_n = 1'b0;
        strobe_b_n = 1'b0;
        step();
        strobe_a_n = 1'b1;
        strobe_b_n = 1'b1;
        chk("R3", beat_addr, 20'h55552);
    endtask

    initial begin
        t_reset();
        t_full_burst(20'h3C5A1, 1'b0, 1'b0);
        t_full_burst(20'h3C5A3, 1'b1, 1'b0);
        t_full_burst(20'h0F0F2, 1'b1, 1'b1);
        t_full_burst(20'h77773, 1'b0, 1'b1);
        t_full_burst(20'h80000, 1'b0, 1'b1);
        t_hold();
        t_reload();
        t_both_strobes();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule